// File: doc/BRIEF.md
# Low-Power Stop Broadcast Controller

This block sits on the processor bus and watches for the one write cycle that announces low-power stop mode. That cycle is a write to processor control space at a fixed address. When the block sees it, it stores the interrupt priority threshold carried in the write data. It then terminates the cycle itself with a short internal acknowledge and gates the system clock enable off.

While the clock is stopped, the block compares the incoming interrupt request level with the stored threshold. A request above the threshold, or a level-7 request, restores the clock enable in the same cycle and raises a one-cycle wake pulse. Reset also restores the clock. A visibility flag tells the external bus interface whether to show the broadcast outside the chip. The broadcast is shown only when the bus has not been granted to another master.

Top module: `lpstop_ctrl`

## Requirements
- R1: A broadcast is recognised when all of the following hold in the same cycle: bus_strobe, bus_write and cpu_space are high, bus_addr equals STOP_ADDR (default 0x3FFFE), and every bus_data bit outside 10:8 is zero. Any cycle that misses one of these conditions produces no acknowledge.
- R2: On recognition the block stores bus_data[10:8] as the wake threshold. Reset sets the stored threshold to 7.
- R3: int_ack is high for exactly ACK_CYC cycles, starting in the cycle after the recognition edge.
- R4: bus_err has no effect. The acknowledge length, the stored threshold and the entry into stop are the same with bus_err high or low.
- R5: ext_visible is high together with int_ack when bus_granted_away was low at recognition. It stays low for the whole broadcast when bus_granted_away was high.
- R6: clk_enable goes low in the cycle after the last int_ack cycle. It stays low while no wake condition is present.
- R7: While clk_enable is gated off, an irq_level above the stored threshold, or irq_level equal to 7, drives clk_enable high and wake_pulse high in that same cycle. From the next cycle the block is running, with wake_pulse low.
- R8: While clk_enable is gated off, an irq_level of 6 or less that does not exceed the stored threshold leaves clk_enable and wake_pulse low.
- R9: A broadcast presented while the block is acknowledging or stopped is ignored. It causes no new acknowledge and does not change the stored threshold.
- R10: Asserting rst_n low at any time immediately forces clk_enable high and int_ack, ext_visible and wake_pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| bus_strobe | input | 1 | Address strobe; the cycle is valid |
| bus_write | input | 1 | High for a write cycle |
| cpu_space | input | 1 | Cycle targets processor control space |
| bus_granted_away | input | 1 | Another master owns the external bus |
| bus_err | input | 1 | Bus error; ignored by this block |
| irq_level | input | 3 | Highest pending interrupt priority |
| int_ack | output | 1 | Internal cycle acknowledge |
| ext_visible | output | 1 | Show the broadcast on the external bus |
| clk_enable | output | 1 | System clock enable |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The bench builds the block with ACK_CYC set to 2 instead of the default 1. This exposes the acknowledge counter and shows that bus_err stays harmless across a multi-cycle acknowledge. ADDR_W and STOP_ADDR keep their defaults, so addresses one bit away from 0x3FFFE test the exact decode. Random thresholds from 0 to 7 cover the strict-greater comparison at both ends, including the saturated threshold where only level 7 wakes.

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] STOP_ADDR = 20'h3FFFE,
  parameter int MASK_LSB = 8,
  parameter int ACK_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_strobe,
  input  logic              bus_write,
  input  logic              cpu_space,
  input  logic              bus_granted_away,
  input  logic              bus_err,
  input  logic [2:0]        irq_level,
  output logic              int_ack,
  output logic              ext_visible,
  output logic              clk_enable,
  output logic              wake_pulse
);

  localparam int CNT_W = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
  localparam logic [DATA_W-1:0] FIELD = {{(DATA_W-3){1'b0}}, 3'b111} << MASK_LSB;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_CYC - 1);

  typedef enum logic [1:0] {RUN, ACKING, STOPPED} st_e;

  st_e              state;
  logic [2:0]       held_mask;
  logic [CNT_W-1:0] cnt;
  logic             show_q;

  logic hit, wake_cond;

  assign hit = bus_strobe && bus_write && cpu_space && (bus_addr == STOP_ADDR)
               && ((bus_data & ~FIELD) == '0);
  assign wake_cond   = (irq_level > held_mask) || (irq_level == 3'd7);
  assign int_ack     = (state == ACKING);
  assign ext_visible = int_ack && show_q;
  assign wake_pulse  = (state == STOPPED) && wake_cond;
  assign clk_enable  = (state != STOPPED) || wake_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RUN;
      held_mask <= 3'd7;
      cnt       <= '0;
      show_q    <= 1'b0;
    end else begin
      case (state)
        RUN: if (hit) begin
          state     <= ACKING;
          held_mask <= bus_data[MASK_LSB +: 3];
          show_q    <= !bus_granted_away;
          cnt       <= '0;
        end
        ACKING: begin
          if (cnt == LAST) state <= STOPPED;
          else cnt <= cnt + 1'b1;
        end
        STOPPED: if (wake_cond) state <= RUN;
        default: state <= RUN;
      endcase
    end
  end

  // R2
  mask_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == RUN && hit) |-> held_mask == $past(bus_data[MASK_LSB +: 3]));

  // R3
  ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && hit) |=> int_ack);

  // R4
  berr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && bus_err && cnt == LAST) |=> state == STOPPED);

  // R5
  ext_only_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_visible |-> int_ack);

  // R7
  nmi_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'd7) |-> clk_enable);

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse && clk_enable);

  // R6
  gated_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_enable |-> !int_ack);

endmodule

// File: tb/test_lpstop_ctrl.sv
`timescale 1ns/1ps
module test_lpstop_ctrl;
  localparam int ACK_CYC = 2;
  localparam logic [19:0] SADDR = 20'h3FFFE;

  logic clk = 0, rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic bus_strobe = 0, bus_write = 0, cpu_space = 0, bus_granted_away = 0, bus_err = 0;
  logic [2:0] irq_level = '0;
  logic int_ack, ext_visible, clk_enable, wake_pulse;
  int checks = 0, failures = 0;
  bit done = 0;

  lpstop_ctrl #(.ACK_CYC(ACK_CYC)) i_lpstop_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .cpu_space(cpu_space),
    .bus_granted_away(bus_granted_away), .bus_err(bus_err), .irq_level(irq_level),
    .int_ack(int_ack), .ext_visible(ext_visible), .clk_enable(clk_enable),
    .wake_pulse(wake_pulse));

  always #10 clk = ~clk;

  function automatic bit exp_wake(input logic [2:0] lvl, input logic [2:0] m);
    return (lvl > m) || (lvl == 3'd7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    bus_strobe = 0; bus_write = 0; cpu_space = 0; bus_addr = '0; bus_data = '0;
  endtask

  task automatic present(input logic [19:0] a, input logic [15:0] d,
                         input logic w, input logic cs, input logic ga);
    bus_addr = a; bus_data = d; bus_write = w; cpu_space = cs;
    bus_granted_away = ga; bus_strobe = 1;
  endtask

  task automatic reject(input string req, input logic [19:0] a, input logic [15:0] d,
                        input logic w, input logic cs);
    @(negedge clk); present(a, d, w, cs, 0);
    @(negedge clk); drive_idle();
    chk(req, int_ack, 0);
    @(negedge clk); chk(req, clk_enable, 1);
  endtask

  task automatic broadcast(input logic [2:0] m, input logic ga, input logic be);
    @(negedge clk); irq_level = 0; present(SADDR, {5'b0, m, 8'b0}, 1, 1, ga);
    @(negedge clk); drive_idle(); bus_err = be;
    chk("R3 ack", int_ack, 1);
    chk("R5 ext", ext_visible, !ga);
    for (int k = 1; k < ACK_CYC; k++) begin
      @(negedge clk);
      chk("R3 ack hold", int_ack, 1);
      chk("R5 ext hold", ext_visible, !ga);
      chk("R4 berr ack", clk_enable, 1);
    end
    @(negedge clk); bus_err = 0;
    chk("R3 ack end", int_ack, 0);
    chk("R6 gate", clk_enable, 0);
  endtask

  task automatic try_level(input logic [2:0] lvl, input logic [2:0] m);
    bit w;
    w = exp_wake(lvl, m);
    @(negedge clk); irq_level = lvl; #1;
    chk(w ? "R7 wake en" : "R8 no wake en", clk_enable, w);
    chk(w ? "R7 wake pulse" : "R8 no pulse", wake_pulse, w);
    if (w) begin
      @(negedge clk);
      chk("R7 running", clk_enable, 1);
      chk("R7 pulse once", wake_pulse, 0);
      irq_level = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] m, lvl;
    void'($urandom(32'd4242));
    #5;
    chk("R10 reset en", clk_enable, 1);
    chk("R10 reset ack", int_ack, 0);
    chk("R10 reset wake", wake_pulse, 0);
    @(negedge clk); rst_n = 1;

    reject("R1 addr", SADDR ^ 20'h1, 16'h0300, 1, 1);
    reject("R1 addr hi", SADDR ^ 20'h20000, 16'h0300, 1, 1);
    reject("R1 read", SADDR, 16'h0300, 0, 1);
    reject("R1 space", SADDR, 16'h0300, 1, 0);
    reject("R1 data lo", SADDR, 16'h0301, 1, 1);
    reject("R1 data hi", SADDR, 16'h8300, 1, 1);

    broadcast(3'd3, 0, 1);
    try_level(3'd3, 3'd3);
    @(negedge clk); present(SADDR, 16'h0000, 1, 1, 0);
    @(negedge clk); drive_idle();
    chk("R9 no reack", int_ack, 0);
    chk("R9 stays gated", clk_enable, 0);
    try_level(3'd1, 3'd3);
    try_level(3'd4, 3'd3);

    broadcast(3'd7, 1, 0);
    try_level(3'd6, 3'd7);
    try_level(3'd7, 3'd7);

    broadcast(3'd0, 0, 0);
    @(negedge clk); rst_n = 0; #1;
    chk("R10 async en", clk_enable, 1);
    chk("R10 async ack", int_ack, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 40; i++) begin
      m = 3'($urandom_range(0, 7));
      broadcast(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int j = 0; j < 3; j++) begin
        lvl = 3'($urandom_range(0, 6));
        if (!exp_wake(lvl, m)) try_level(lvl, m);
      end
      lvl = 3'($urandom_range(0, 7));
      while (!exp_wake(lvl, m)) lvl = 3'($urandom_range(0, 7));
      try_level(lvl, m);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule